// File: doc/BRIEF.md
# Write-Forwarding Simple Dual-Port Memory

This block is a memory with one write port and one read port. Both ports run from the same clock edge. A sampling engine stores results through the write port. A host reads the stored history back through the read port whenever it likes. The array holds 512 bytes. The address is the concatenation of a 3-bit channel number and a 6-bit slot number, so eight channels of 64 samples each fill the array exactly.

Only one port writes, so the two ports never need to arbitrate between writes. The one hazard is a read that targets the word being written on the same edge. Plain memory gives an undefined value in that case. This block instead compares the two addresses. When they match and both enables are high, it returns the incoming write data. The write into the array still completes as normal.

Read data is registered, with one cycle from the read request to the output. Forwarded data arrives with the same one-cycle latency.

Top module: `sdpr_fwd_ram`

## Requirements
- R1: `rst` is a synchronous, active-high reset. After any edge at which `rst` is sampled high, `rd_data` is 0. The array contents are not cleared by reset.
- R2: At an edge where `wr_en` is high and `rst` is low, `wr_data` is stored at `wr_addr`.
- R3: At an edge where `rd_en` is high and no collision occurs, `rd_data` shows the word stored at `rd_addr` from just after that edge. That is one cycle of latency.
- R4: A collision is an edge where `wr_en` and `rd_en` are both high and `wr_addr` equals `rd_addr`. At a collision, `rd_data` shows `wr_data` from just after that edge.
- R5: A write made during a collision is stored in the array. A later read of that address returns it.
- R6: At an edge where `rd_en` is low, `rd_data` keeps its previous value, whatever the write port does.
- R7: When `wr_en` is low, a matching `wr_addr` has no effect. The read returns the stored word, not `wr_data`.
- R8: A write requested at an edge where `rst` is high is ignored, and the addressed word keeps its old contents.
- R9: The address is {channel[2:0], slot[5:0]}. All 512 words are independent storage locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | 9 | Write address {channel, slot} |
| wr_data | input | 8 | Byte to store |
| rd_en | input | 1 | Read request |
| rd_addr | input | 9 | Read address {channel, slot} |
| rd_data | output | 8 | Registered read result |

## Verification
The hardest case to reach from the ports is a collision that must be told apart from an ordinary read. For that, the stored word and the incoming write data must differ. The bench first fills all 512 words with a known pattern. It then forces collisions with write data unlike that pattern, including back-to-back collisions on one address with changing data. Each collision is followed by a plain read that confirms the write landed. Variants where one enable is low while the addresses match show that forwarding needs both enables.

// File: rtl/sdpr_pkg.sv
package sdpr_pkg;
    localparam int DATA_W_DEF   = 8;
    localparam int CHANNELS_DEF = 8;
    localparam int SLOTS_DEF    = 64;

    // True when the write and read requests touch the same word in one cycle.
    function automatic logic same_word_hit(input logic we, input logic re,
                                           input logic [31:0] wa,
                                           input logic [31:0] ra);
        return we && re && (wa == ra);
    endfunction
endpackage

// File: rtl/sdpr_array.sv
module sdpr_array #(
    parameter int DATA_W = sdpr_pkg::DATA_W_DEF,
    parameter int ADDR_W = 9,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] wa,
    input  logic [DATA_W-1:0] wd,
    input  logic              re,
    input  logic [ADDR_W-1:0] ra,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] store [DEPTH];

    // Storage has no reset; only the output register is cleared.
    always_ff @(posedge clk) begin
        if (we) store[wa] <= wd;
    end

    // Read-before-write: the old word is captured when addresses match.
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (re) q <= store[ra];
    end
endmodule

// File: rtl/sdpr_bypass.sv
module sdpr_bypass #(
    parameter int DATA_W = sdpr_pkg::DATA_W_DEF,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] wa,
    input  logic [DATA_W-1:0] wd,
    input  logic              re,
    input  logic [ADDR_W-1:0] ra,
    output logic              hit_q,
    output logic [DATA_W-1:0] fwd_q
);
    import sdpr_pkg::*;

    logic hit_now;
    assign hit_now = same_word_hit(we, re, 32'(wa), 32'(ra));

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q <= 1'b0;
            fwd_q <= '0;
        end else if (re) begin
            hit_q <= hit_now;
            fwd_q <= wd;
        end
    end

    // R4: a registered hit always carries the data written at the collision
    a_r4_hit_carries_write: assert property (@(posedge clk) disable iff (rst)
        (re && we && wa == ra) |=> (hit_q && fwd_q == $past(wd)));
endmodule

// File: rtl/sdpr_fwd_ram.sv
module sdpr_fwd_ram #(
    parameter int DATA_W   = sdpr_pkg::DATA_W_DEF,
    parameter int CHANNELS = sdpr_pkg::CHANNELS_DEF,
    parameter int SLOTS    = sdpr_pkg::SLOTS_DEF,
    localparam int ADDR_W  = $clog2(CHANNELS) + $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic              we_g;
    logic [DATA_W-1:0] arr_q;
    logic [DATA_W-1:0] fwd_q;
    logic              hit_q;

    // Writes are held off while reset is asserted.
    assign we_g = wr_en & ~rst;

    sdpr_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst(rst),
        .we(we_g), .wa(wr_addr), .wd(wr_data),
        .re(rd_en), .ra(rd_addr), .q(arr_q)
    );

    sdpr_bypass #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bypass (
        .clk(clk), .rst(rst),
        .we(we_g), .wa(wr_addr), .wd(wr_data),
        .re(rd_en), .ra(rd_addr),
        .hit_q(hit_q), .fwd_q(fwd_q)
    );

    assign rd_data = hit_q ? fwd_q : arr_q;

    // R1: reset clears the read output
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> rd_data == '0);

    // R4: collision returns the incoming write data
    a_r4_forward: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en && wr_addr == rd_addr) |=> rd_data == $past(wr_data));

    // R6: idle read port holds its output
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R3, R7: a read without a collision comes from the array
    a_r3_array_path: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !(wr_en && wr_addr == rd_addr)) |=> rd_data == arr_q);
endmodule

// File: tb/sdpr_fwd_ram_test.sv
module sdpr_fwd_ram_test;
    localparam int AW = 9;
    localparam int DW = 8;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] ref_mem [N];
    logic [DW-1:0] exp_q = '0;

    always #5 clk = ~clk;

    sdpr_fwd_ram uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    typedef struct packed {
        logic          we;
        logic [AW-1:0] wa;
        logic [DW-1:0] wd;
        logic          re;
        logic [AW-1:0] ra;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{1'b1, 9'h010, 8'hA5, 1'b1, 9'h010},   // collision
        '{1'b0, 9'h000, 8'h00, 1'b1, 9'h010},   // read back the forwarded write
        '{1'b1, 9'h1FF, 8'h3C, 1'b1, 9'h000},   // write and read, different words
        '{1'b1, 9'h040, 8'hC3, 1'b0, 9'h040},   // matching addresses, read idle
        '{1'b0, 9'h040, 8'h77, 1'b1, 9'h040},   // matching addresses, write idle
        '{1'b1, 9'h0BF, 8'h11, 1'b1, 9'h0BF},   // collision, last slot of channel 2
        '{1'b1, 9'h0BF, 8'h22, 1'b1, 9'h0BF},   // back-to-back collision
        '{1'b0, 9'h000, 8'h00, 1'b1, 9'h0BF},
        '{1'b1, 9'h100, 8'h5A, 1'b1, 9'h000},   // same slot, other channel
        '{1'b0, 9'h000, 8'h00, 1'b1, 9'h100},
        '{1'b0, 9'h000, 8'h00, 1'b0, 9'h1FF},   // idle
        '{1'b0, 9'h000, 8'h00, 1'b1, 9'h1FF}
    };

    function automatic logic [DW-1:0] pat(input int a);
        return DW'((a * 37 + 11) ^ (a >> 3));
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] exp);
        checks++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s: rd_data=%h expected=%h", tag, rd_data, exp);
        end
    endtask

    // One clock: drive at falling edge, update the model, sample after rising edge.
    task automatic step(input logic we, input logic [AW-1:0] wa,
                        input logic [DW-1:0] wd, input logic re,
                        input logic [AW-1:0] ra, input string tag,
                        input logic do_check);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
        if (rst)                exp_q = '0;
        else if (re && we && wa == ra) exp_q = wd;
        else if (re)            exp_q = ref_mem[ra];
        if (we && !rst) ref_mem[wa] = wd;
        @(posedge clk);
        #1;
        if (do_check) check(tag, exp_q);
    endtask

    initial begin
        // R1, R8: reset with a write request pending
        rst = 1'b1;
        step(1'b1, 9'h005, 8'hEE, 1'b1, 9'h005, "R1", 1'b1);
        step(1'b0, 9'h000, 8'h00, 1'b0, 9'h000, "R1", 1'b1);
        rst = 1'b0;

        // R2, R9: fill every word with the port idle on the read side
        for (int a = 0; a < N; a++)
            step(1'b1, AW'(a), pat(a), 1'b0, 9'h000, "R6", 1'b0);
        check("R6", 8'h00);

        // R3, R9: read back every word
        for (int a = 0; a < N; a++)
            step(1'b0, 9'h000, 8'h00, 1'b1, AW'(a), "R3", 1'b1);

        // table walk
        for (int i = 0; i < 12; i++) begin
            string tag;
            if (VECS[i].re && VECS[i].we && VECS[i].wa == VECS[i].ra) tag = "R4";
            else if (!VECS[i].re) tag = "R6";
            else if (VECS[i].wa == VECS[i].ra) tag = "R7";
            else tag = "R5";
            step(VECS[i].we, VECS[i].wa, VECS[i].wd, VECS[i].re, VECS[i].ra, tag, 1'b1);
        end

        // R4, R5: collision with data unlike the pattern, then read it back
        step(1'b1, 9'h123, ~pat(9'h123), 1'b1, 9'h123, "R4", 1'b1);
        step(1'b0, 9'h000, 8'h00, 1'b1, 9'h123, "R5", 1'b1);

        // R7: write idle with matching address returns stored word
        step(1'b0, 9'h124, 8'hFF, 1'b1, 9'h124, "R7", 1'b1);

        // R6: collision-shaped write while read idle leaves output alone
        step(1'b1, 9'h124, 8'h01, 1'b0, 9'h124, "R6", 1'b1);
        step(1'b0, 9'h000, 8'h00, 1'b1, 9'h124, "R2", 1'b1);

        // R8, R1: write during reset ignored, array survives reset
        rst = 1'b1;
        step(1'b1, 9'h007, 8'h33, 1'b0, 9'h000, "R1", 1'b1);
        rst = 1'b0;
        step(1'b0, 9'h000, 8'h00, 1'b1, 9'h007, "R8", 1'b1);
        step(1'b0, 9'h000, 8'h00, 1'b1, 9'h1FF, "R1", 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule